// File: doc/BRIEF.md
# Next-PC Source Selector

This block decides where the program counter goes next. A decoder upstream sorts each instruction into one of four next-PC classes: conditional branch, direct jump, jump through a register, or ordinary sequential flow. The block combines that class with the ALU zero flag and a branch-polarity bit. From them it produces a 2-bit source select, and it steers one of four 32-bit candidate addresses onto the next-PC bus.

The polarity bit picks the branch condition. When it is clear, a branch is taken on a zero result, as in a branch-if-equal. When it is set, a branch is taken on a non-zero result, as in a branch-if-not-equal. A branch whose condition fails falls through to the sequential address. Computing the targets and holding the PC register both happen outside this block. The block is purely combinational, and its select and address outputs follow the inputs within the same cycle.

Top module: `npc_select_top`

## Requirements
- R1: The branch condition equals `zeroFlag` when `branchOnNonZero` is 0, and equals the inverse of `zeroFlag` when `branchOnNonZero` is 1.
- R2: When `nextClass` is 2'b00 and the branch condition holds, `pcSelect` is 2'b00 and `nextPc` equals `branchTarget`.
- R3: When `nextClass` is 2'b01, `pcSelect` is 2'b01 and `nextPc` equals `jumpTarget`.
- R4: When `nextClass` is 2'b10, `pcSelect` is 2'b10 and `nextPc` equals `rsValue`.
- R5: When `nextClass` is 2'b11, `pcSelect` is 2'b11 and `nextPc` equals `pcPlus4`.
- R6: When `nextClass` is 2'b00 and the branch condition fails, `pcSelect` is 2'b11 and `nextPc` equals `pcPlus4`.
- R7: `nextPc` always equals the candidate that `pcSelect` names: 00 selects branchTarget, 01 selects jumpTarget, 10 selects rsValue, and 11 selects pcPlus4.
- R8: For `nextClass` values other than 2'b00, `zeroFlag` and `branchOnNonZero` have no effect on `pcSelect` or `nextPc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| nextClass | input | 2 | Next-PC class from decoder (00 branch, 01 jump, 10 register, 11 sequential) |
| zeroFlag | input | 1 | ALU zero result flag |
| branchOnNonZero | input | 1 | Branch polarity: 0 takes the branch on zero, 1 takes it on non-zero |
| branchTarget | input | 32 | Candidate address for a taken branch |
| jumpTarget | input | 32 | Candidate address for a direct jump |
| rsValue | input | 32 | Candidate address read from register rs |
| pcPlus4 | input | 32 | Sequential candidate address |
| pcSelect | output | 2 | Chosen next-PC source |
| nextPc | output | 32 | Selected next program counter |

## Verification
The block holds no state, so any fault appears at the ports in the same cycle as the input that triggers it. A wrong polarity decode shows up as swapped taken and not-taken outcomes for class 00. A wrong select equation sends a jump or register-indirect class to the sequential address. A miswired mux leg puts the wrong candidate on `nextPc` even though `pcSelect` is correct. The candidate addresses are distinct non-zero patterns, so each of these faults changes the observed output.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    CLS_BRANCH = 2'b00,
    CLS_JUMP   = 2'b01,
    CLS_REG    = 2'b10,
    CLS_SEQ    = 2'b11
  } npcClass_e;

  typedef enum logic [1:0] {
    SRC_BRANCH = 2'b00,
    SRC_JUMP   = 2'b01,
    SRC_REG    = 2'b10,
    SRC_SEQ    = 2'b11
  } npcSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    npcSrc_e srcSel;
    logic    condMet;
  } npcStrobe_t;

  localparam int unsigned NUM_SRC = 4;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [1:0] nextClass,
  input  logic       zeroFlag,
  input  logic       branchOnNonZero,
  output npcStrobe_t strobe
);

  logic cond;
  logic [1:0] sel;

  always_comb begin
    // polarity picks zero or its complement
    cond   = zeroFlag ^ branchOnNonZero;
    // a failed branch (class 00, no cond) drives both bits high -> sequential
    sel[0] = nextClass[0] | (~cond & ~nextClass[1]);
    sel[1] = nextClass[1] | (~cond & ~nextClass[0]);
    strobe.srcSel  = npcSrc_e'(sel);
    strobe.condMet = cond;
  end

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter bit          ONEHOT_MUX = 1'b0
) (
  input  npcStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  branchTarget,
  input  logic [ADDR_W-1:0]  jumpTarget,
  input  logic [ADDR_W-1:0]  rsValue,
  input  logic [ADDR_W-1:0]  pcPlus4,
  output logic [ADDR_W-1:0]  nextPc
);

  localparam int unsigned SEL_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0][ADDR_W-1:0] cand;

  assign cand[SRC_BRANCH] = branchTarget;
  assign cand[SRC_JUMP]   = jumpTarget;
  assign cand[SRC_REG]    = rsValue;
  assign cand[SRC_SEQ]    = pcPlus4;

  generate
    if (ONEHOT_MUX) begin : g_andor
      logic [NUM_SRC-1:0] hot;
      always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
          hot[i] = (strobe.srcSel == SEL_W'(i));
        end
      end
      always_comb begin
        nextPc = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
          nextPc = nextPc | (cand[i] & {ADDR_W{hot[i]}});
        end
      end
    end else begin : g_index
      assign nextPc = cand[strobe.srcSel];
    end
  endgenerate

endmodule

// File: rtl/npc_select_top.sv
module npc_select_top
  import npc_pkg::*;
(
  input  logic [1:0]  nextClass,
  input  logic        zeroFlag,
  input  logic        branchOnNonZero,
  input  logic [31:0] branchTarget,
  input  logic [31:0] jumpTarget,
  input  logic [31:0] rsValue,
  input  logic [31:0] pcPlus4,
  output logic [1:0]  pcSelect,
  output logic [31:0] nextPc
);

  npcStrobe_t strobe;

  npc_ctrl i_ctrl (
    .nextClass       (nextClass),
    .zeroFlag        (zeroFlag),
    .branchOnNonZero (branchOnNonZero),
    .strobe          (strobe)
  );

  npc_datapath #(
    .ADDR_W     (32),
    .ONEHOT_MUX (1'b0)
  ) i_dp (
    .strobe       (strobe),
    .branchTarget (branchTarget),
    .jumpTarget   (jumpTarget),
    .rsValue      (rsValue),
    .pcPlus4      (pcPlus4),
    .nextPc       (nextPc)
  );

  assign pcSelect = strobe.srcSel;

endmodule

// File: rtl/npc_select_checker.sv
module npc_select_checker (
  input logic [1:0]  nextClass,
  input logic        zeroFlag,
  input logic        branchOnNonZero,
  input logic [31:0] branchTarget,
  input logic [31:0] jumpTarget,
  input logic [31:0] rsValue,
  input logic [31:0] pcPlus4,
  input logic [1:0]  pcSelect,
  input logic [31:0] nextPc
);

  logic cond;
  assign cond = branchOnNonZero ? ~zeroFlag : zeroFlag;

  always_comb begin
    // R1 and R2: taken branch
    p_branch_taken_r2: assert (!((nextClass == 2'b00) && cond) || (pcSelect == 2'b00))
      else $error("branch taken select wrong");
    // R1 and R6: failed branch falls through
    p_branch_fall_r6: assert (!((nextClass == 2'b00) && !cond) || (pcSelect == 2'b11))
      else $error("branch fall-through select wrong");
    p_jump_r3: assert (!(nextClass == 2'b01) || (pcSelect == 2'b01))
      else $error("jump select wrong");
    p_reg_r4: assert (!(nextClass == 2'b10) || (pcSelect == 2'b10))
      else $error("register select wrong");
    p_seq_r5: assert (!(nextClass == 2'b11) || (pcSelect == 2'b11))
      else $error("sequential select wrong");
    // R8: outside class 00 select equals class
    p_class_passthru_r8: assert ((nextClass == 2'b00) || (pcSelect == nextClass))
      else $error("select depends on flags outside branch class");
    p_mux_branch_r7: assert (!(pcSelect == 2'b00) || (nextPc == branchTarget))
      else $error("mux leg 00 wrong");
    p_mux_jump_r7: assert (!(pcSelect == 2'b01) || (nextPc == jumpTarget))
      else $error("mux leg 01 wrong");
    p_mux_reg_r7: assert (!(pcSelect == 2'b10) || (nextPc == rsValue))
      else $error("mux leg 10 wrong");
    p_mux_seq_r7: assert (!(pcSelect == 2'b11) || (nextPc == pcPlus4))
      else $error("mux leg 11 wrong");
  end

endmodule

bind npc_select_top npc_select_checker i_chk (
  .nextClass       (nextClass),
  .zeroFlag        (zeroFlag),
  .branchOnNonZero (branchOnNonZero),
  .branchTarget    (branchTarget),
  .jumpTarget      (jumpTarget),
  .rsValue         (rsValue),
  .pcPlus4         (pcPlus4),
  .pcSelect        (pcSelect),
  .nextPc          (nextPc)
);

// File: tb/test_npc_select_top.sv
module test_npc_select_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  nextClass = 2'b00;
  logic        zeroFlag = 1'b0;
  logic        branchOnNonZero = 1'b0;
  logic [31:0] branchTarget = '0;
  logic [31:0] jumpTarget = '0;
  logic [31:0] rsValue = '0;
  logic [31:0] pcPlus4 = '0;
  logic [1:0]  pcSelect;
  logic [31:0] nextPc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  npc_select_top i_npc_select_top (
    .nextClass       (nextClass),
    .zeroFlag        (zeroFlag),
    .branchOnNonZero (branchOnNonZero),
    .branchTarget    (branchTarget),
    .jumpTarget      (jumpTarget),
    .rsValue         (rsValue),
    .pcPlus4         (pcPlus4),
    .pcSelect        (pcSelect),
    .nextPc          (nextPc)
  );

  task automatic check(string req, logic [1:0] expSel, logic [31:0] expPc);
    checks++;
    if (pcSelect !== expSel || nextPc !== expPc) begin
      failures++;
      $display("FAIL %s: sel=%b pc=%h expected sel=%b pc=%h",
               req, pcSelect, nextPc, expSel, expPc);
    end
  endtask

  // drive at posedge, sample at the following negedge
  task automatic apply(logic [1:0] cls, logic z, logic pol, int seed);
    @(posedge clk);
    nextClass       = cls;
    zeroFlag        = z;
    branchOnNonZero = pol;
    branchTarget    = 32'h1000_0040 + 32'(seed);
    jumpTarget      = 32'h2000_0080 + 32'(seed);
    rsValue         = 32'h3000_00C0 + 32'(seed);
    pcPlus4         = 32'h4000_0004 + 32'(seed);
    @(negedge clk);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    // all inputs zero: class 00, zero 0, polarity 0 -> condition false -> sequential
    check("R6 reset", 2'b11, 32'h0);
  endtask

  task automatic test_branch_on_zero();
    apply(2'b00, 1'b1, 1'b0, 4);
    check("R1/R2 beq taken", 2'b00, branchTarget);
    apply(2'b00, 1'b0, 1'b0, 8);
    check("R1/R6 beq not taken", 2'b11, pcPlus4);
  endtask

  task automatic test_branch_on_nonzero();
    apply(2'b00, 1'b0, 1'b1, 12);
    check("R1/R2 bne taken", 2'b00, branchTarget);
    apply(2'b00, 1'b1, 1'b1, 16);
    check("R1/R6 bne not taken", 2'b11, pcPlus4);
  endtask

  task automatic test_jump();
    for (int f = 0; f < 4; f++) begin
      apply(2'b01, f[0], f[1], 20 + 4 * f);
      check("R3/R8 jump", 2'b01, jumpTarget);
    end
  endtask

  task automatic test_reg();
    for (int f = 0; f < 4; f++) begin
      apply(2'b10, f[0], f[1], 40 + 4 * f);
      check("R4/R8 register", 2'b10, rsValue);
    end
  endtask

  task automatic test_seq();
    for (int f = 0; f < 4; f++) begin
      apply(2'b11, f[0], f[1], 60 + 4 * f);
      check("R5/R8 sequential", 2'b11, pcPlus4);
    end
  endtask

  task automatic test_mux_patterns();
    // R7: distinctive bit patterns on every leg
    @(posedge clk);
    branchTarget = 32'hFFFF_0000; jumpTarget = 32'h0000_FFFF;
    rsValue = 32'hAAAA_5555; pcPlus4 = 32'h5555_AAAA;
    nextClass = 2'b00; zeroFlag = 1'b1; branchOnNonZero = 1'b0;
    @(negedge clk);
    check("R7 leg00", 2'b00, 32'hFFFF_0000);
    @(posedge clk); nextClass = 2'b01;
    @(negedge clk);
    check("R7 leg01", 2'b01, 32'h0000_FFFF);
    @(posedge clk); nextClass = 2'b10;
    @(negedge clk);
    check("R7 leg10", 2'b10, 32'hAAAA_5555);
    @(posedge clk); nextClass = 2'b11;
    @(negedge clk);
    check("R7 leg11", 2'b11, 32'h5555_AAAA);
  endtask

  initial begin
    test_reset_state();
    repeat (2) @(posedge clk);
    rst = 1'b0;
    test_branch_on_zero();
    test_branch_on_nonzero();
    test_jump();
    test_reg();
    test_seq();
    test_mux_patterns();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++;
          failures++;
          $display("FAIL watchdog: run did not complete, expected completion");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule